// File: doc/BRIEF.md
# Carry-Save Blakley Modular Multiplier

The block computes `opA * opB mod opN` for unsigned operands of `WIDTH` bits. It uses the interleaved method: the multiplier `opB` is scanned from its most significant bit down. For each bit the running partial product is doubled and, if the bit is set, the multiplicand is added. The partial product is then brought back into range by conditional subtraction of the modulus. The partial product never leaves redundant carry-save form during the loop, so no carry has to travel across the full width inside the iteration.

Each subtraction is tried as a carry-save candidate. Whether it is kept is decided from a four-bit carry-lookahead sum of the top bits of the candidate pair, which gives an estimate of its sign. On an accepted start the modulus and multiplicand are shifted left until the modulus has its top bit set. This keeps the resolution of the estimate matched to the modulus, whatever its length. The result is shifted back at the end. Each multiplier bit takes three cycles: shift-add, a trial subtraction of twice the modulus, and a trial subtraction of the modulus. One more cycle then turns the redundant pair into a single word, subtracts the modulus once more if that is needed, and shifts the word back down.

Operands must satisfy `opN > 1` and `opA, opB < opN`; any other input gives an unspecified result.

Top module: `blakley_modmul`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `busy` and `done` are 0 and `result` is 0.
- R2: `start` is accepted only on a rising edge where `busy` is 0. A `start` that is high while `busy` is 1 has no effect: the running operation finishes with its own operands, and no second operation follows it.
- R3: For `opN > 1` and `opA, opB < opN`, sampled on the accepting edge, `result` equals `(opA * opB) mod opN` when `done` is high.
- R4: `done` is high for exactly one cycle, following the rising edge that is 3*WIDTH+1 edges after the accepting edge. `busy` is 1 from the accepting edge up to that edge, and 0 after it.
- R5: `result` changes only on the edge that raises `done`. It then holds through later idle cycles, whatever the operand inputs do.
- R6: After the two trial subtractions of every multiplier bit, the carry-save pair sums to a value in [0, 2N'), where N' is the modulus after the alignment shift. The final step brings this value into [0, N'). This holds even for the largest operands, `opA = opB = opN - 1`.
- R7: A trial subtraction is kept only when the four-bit sign estimate, taken from the top four bits of the candidate pair, is non-negative. A kept candidate is never negative. A declined candidate is below 2^(WIDTH-1). This holds at both extremes of the aligned modulus, N' = 2^(WIDTH-1) and N' = 2^WIDTH - 1.
- R8: Moduli of every bit length from 2 up to 2^WIDTH - 1 give the correct residue. The operands are aligned by the leading-zero count of `opN`, and the result is shifted back by the same count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Requests a new multiplication; accepted only when idle |
| opA | input | WIDTH | Multiplicand |
| opB | input | WIDTH | Multiplier, scanned from its top bit down |
| opN | input | WIDTH | Modulus |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | WIDTH | Reduced product, held until the next operation completes |

## Verification
Counting the accepting edge as edge 0, `busy` is due at 1 before edge 1, and `done` and `result` are due after edge 3*WIDTH+1. That is edge 49 for the 16-bit instance and edge 13 for the 4-bit instance. The bench drives inputs on the falling edge and counts rising edges from the accepting one. It samples on each following falling edge until `done` appears, then compares the edge count with 3*WIDTH+1 and the value with the arithmetic residue. For the hold and ignore checks, the bench waits a fixed number of falling edges after `done`. It then confirms that `result`, `busy` and `done` have not moved.

// File: rtl/blakley_pkg.sv
package blakley_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_RED_DBL,
    ST_RED_ONE,
    ST_FIX
  } ctrl_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture and align operands
    logic shiftAdd;  // pair <- 2*pair + bit*A'
    logic reduce;    // try a subtraction of the modulus term
    logic dblMod;    // modulus term is 2*N' (else N')
    logic finish;    // resolve pair, correct, shift back
  } dp_strobe_t;

  localparam int EST_BITS = 4;  // width of the sign-estimate window

endpackage

// File: rtl/blakley_csa.sv
module blakley_csa #(
  parameter int W = 19
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  input  logic         carryIn,
  output logic [W-1:0] sumOut,
  output logic [W-1:0] carryOut
);

  assign carryOut[0] = carryIn;

  // one full-adder cell per bit; the top carry falls outside the modulus 2^W
  for (genvar i = 0; i < W; i++) begin : g_cell
    assign sumOut[i] = x[i] ^ y[i] ^ z[i];
    if (i < W - 1) begin : g_carry
      assign carryOut[i+1] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
    end
  end

endmodule

// File: rtl/blakley_sign_est.sv
module blakley_sign_est #(
  parameter int EW = 4
) (
  input  logic [EW-1:0] winC,
  input  logic [EW-1:0] winS,
  output logic          negative
);

  logic [EW-2:0] gen;
  logic [EW-1:1] prop;
  logic          carryTop;

  assign gen  = winC[EW-2:0] & winS[EW-2:0];
  assign prop = winC[EW-1:1] ^ winS[EW-1:1];

  // two-level lookahead for the carry into the top bit of the window
  function automatic logic topCarry(input logic [EW-2:0] g, input logic [EW-1:1] p);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < EW - 1; j++) begin
      term = g[j];
      for (int k = j + 1; k < EW - 1; k++) begin
        term = term & p[k];
      end
      acc = acc | term;
    end
    return acc;
  endfunction

  assign carryTop = topCarry(gen, prop);
  assign negative = prop[EW-1] ^ carryTop;

endmodule

// File: rtl/blakley_datapath.sv
module blakley_datapath
  import blakley_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  dp_strobe_t       ctl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opN,
  output logic [WIDTH-1:0] result
);

  localparam int W   = WIDTH + 3;
  localparam int SHW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam int EW  = EST_BITS;

  logic [W-1:0]     carryQ, sumQ;
  logic [WIDTH-1:0] aNorm, nNorm, bReg, resultQ;
  logic [SHW-1:0]   shiftAmt, lzNow;

  // leading-zero count of the modulus (N > 1 keeps it below WIDTH-1)
  function automatic logic [SHW-1:0] leadZeros(input logic [WIDTH-1:0] v);
    logic [SHW-1:0] cnt;
    cnt = SHW'(WIDTH - 1);
    for (int i = 0; i < WIDTH; i++) begin
      if (v[i]) cnt = SHW'(WIDTH - 1 - i);
    end
    return cnt;
  endfunction

  assign lzNow = leadZeros(opN);

  // shift-add candidate
  logic [W-1:0] dblC, dblS, addend, saSum, saCarry;
  assign dblC   = {carryQ[W-2:0], 1'b0};
  assign dblS   = {sumQ[W-2:0], 1'b0};
  assign addend = bReg[WIDTH-1] ? {3'b000, aNorm} : '0;

  blakley_csa #(.W(W)) u_csaShift (
    .x(dblC), .y(dblS), .z(addend), .carryIn(1'b0),
    .sumOut(saSum), .carryOut(saCarry)
  );

  // trial subtraction candidate: pair + ~K + 1
  logic [W-1:0] modTerm, rdSum, rdCarry;
  assign modTerm = ctl.dblMod ? {2'b00, nNorm, 1'b0} : {3'b000, nNorm};

  blakley_csa #(.W(W)) u_csaReduce (
    .x(carryQ), .y(sumQ), .z(~modTerm), .carryIn(1'b1),
    .sumOut(rdSum), .carryOut(rdCarry)
  );

  logic estNeg, takeSub;
  blakley_sign_est #(.EW(EW)) u_signEst (
    .winC(rdCarry[W-1:W-EW]), .winS(rdSum[W-1:W-EW]), .negative(estNeg)
  );
  assign takeSub = ~estNeg;

  // final resolve and correction
  logic [W-1:0]     pairVal;
  logic [W:0]       trial;
  logic [WIDTH-1:0] fixedVal;
  assign pairVal  = carryQ + sumQ;
  assign trial    = {1'b0, pairVal} - {4'b0000, nNorm};
  assign fixedVal = trial[W] ? pairVal[WIDTH-1:0] : trial[WIDTH-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      carryQ   <= '0;
      sumQ     <= '0;
      aNorm    <= '0;
      nNorm    <= '0;
      bReg     <= '0;
      shiftAmt <= '0;
      resultQ  <= '0;
    end else begin
      if (ctl.load) begin
        carryQ   <= '0;
        sumQ     <= '0;
        aNorm    <= opA << lzNow;
        nNorm    <= opN << lzNow;
        bReg     <= opB;
        shiftAmt <= lzNow;
      end
      if (ctl.shiftAdd) begin
        carryQ <= saCarry;
        sumQ   <= saSum;
        bReg   <= {bReg[WIDTH-2:0], 1'b0};
      end
      if (ctl.reduce && takeSub) begin
        carryQ <= rdCarry;
        sumQ   <= rdSum;
      end
      if (ctl.finish) begin
        resultQ <= fixedVal >> shiftAmt;
      end
    end
  end

  assign result = resultQ;

  // full value of the trial candidate, for checking the estimate
  logic [W-1:0] candVal;
  assign candVal = rdCarry + rdSum;

  AST_SUB_NONNEG: assert property (@(posedge clk) disable iff (rst)
    (ctl.reduce && takeSub) |-> !candVal[W-1]);  // R7

  AST_DECLINE_SMALL: assert property (@(posedge clk) disable iff (rst)
    (ctl.reduce && !takeSub) |-> (candVal[W-1] || candVal[W-2:WIDTH-1] == '0));  // R7

  AST_PARTIAL_BOUND: assert property (@(posedge clk) disable iff (rst)
    (ctl.shiftAdd || ctl.finish) |-> (pairVal < {2'b00, nNorm, 1'b0}));  // R6

  AST_FIX_RANGE: assert property (@(posedge clk) disable iff (rst)
    ctl.finish |-> (trial[W] || trial[W-1:WIDTH] == '0));  // R6

  AST_ALIGNED_MOD: assert property (@(posedge clk) disable iff (rst)
    ctl.shiftAdd |-> nNorm[WIDTH-1]);  // R8

endmodule

// File: rtl/blakley_ctrl.sv
module blakley_ctrl
  import blakley_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output dp_strobe_t ctl
);

  localparam int CW      = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam int LAT     = 3 * WIDTH + 1;
  localparam int LAT_W   = $clog2(LAT + 2) + 1;

  ctrl_state_t    state;
  logic [CW-1:0]  bitCnt;
  logic           doneQ;

  assign busy = (state != ST_IDLE);
  assign done = doneQ;

  always_comb begin
    ctl          = '0;
    ctl.load     = (state == ST_IDLE) && start;
    ctl.shiftAdd = (state == ST_SHIFT);
    ctl.reduce   = (state == ST_RED_DBL) || (state == ST_RED_ONE);
    ctl.dblMod   = (state == ST_RED_DBL);
    ctl.finish   = (state == ST_FIX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_SHIFT;
            bitCnt <= CW'(WIDTH - 1);
          end
        end
        ST_SHIFT:   state <= ST_RED_DBL;
        ST_RED_DBL: state <= ST_RED_ONE;
        ST_RED_ONE: begin
          if (bitCnt == '0) begin
            state <= ST_FIX;
          end else begin
            bitCnt <= bitCnt - 1'b1;
            state  <= ST_SHIFT;
          end
        end
        ST_FIX: begin
          state <= ST_IDLE;
          doneQ <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // edge counter for the latency check
  logic [LAT_W-1:0] latCnt;
  always_ff @(posedge clk) begin
    if (rst) latCnt <= '0;
    else if (ctl.load) latCnt <= '0;
    else if (busy) latCnt <= latCnt + 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> !doneQ);  // R4

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    doneQ |-> (latCnt == LAT_W'(LAT)));  // R4

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (state == ST_SHIFT));  // R2

  AST_NO_ABORT: assert property (@(posedge clk) disable iff (rst)
    (busy && state != ST_FIX) |=> busy);  // R2

  AST_LAST_BIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIX) |-> ($past(state) == ST_RED_ONE && $past(bitCnt) == '0));  // R4

endmodule

// File: rtl/blakley_modmul.sv
module blakley_modmul
  import blakley_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opN,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);

  dp_strobe_t ctl;

  blakley_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .done(done), .ctl(ctl)
  );

  blakley_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk(clk), .rst(rst), .ctl(ctl),
    .opA(opA), .opB(opB), .opN(opN), .result(result)
  );

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));  // R5

endmodule

// File: tb/blakley_modmul_bench.sv
module blakley_modmul_bench;

  localparam int BIG = 16;
  localparam int SML = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic           startBig = 1'b0, startSml = 1'b0;
  logic [BIG-1:0] aBig = '0, bBig = '0, nBig = '0;
  logic [SML-1:0] aSml = '0, bSml = '0, nSml = '0;
  logic           busyBig, doneBig, busySml, doneSml;
  logic [BIG-1:0] resBig;
  logic [SML-1:0] resSml;

  blakley_modmul #(.WIDTH(BIG)) u_blakley_modmul (
    .clk(clk), .rst(rst), .start(startBig), .opA(aBig), .opB(bBig), .opN(nBig),
    .busy(busyBig), .done(doneBig), .result(resBig)
  );

  blakley_modmul #(.WIDTH(SML)) u_blakley_modmul_small (
    .clk(clk), .rst(rst), .start(startSml), .opA(aSml), .opB(bSml), .opN(nSml),
    .busy(busySml), .done(doneSml), .result(resSml)
  );

  int  errors = 0;
  int  checks = 0;
  bit  finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit selBusy(input bit sml);
    return sml ? busySml : busyBig;
  endfunction
  function automatic bit selDone(input bit sml);
    return sml ? doneSml : doneBig;
  endfunction
  function automatic longint selRes(input bit sml);
    return sml ? longint'(resSml) : longint'(resBig);
  endfunction

  // one operation; injectAt > 0 pulses start with other operands while busy
  task automatic runOp(input bit sml, input longint a, input longint b, input longint n,
                       input string req, input int injectAt);
    int     lat;
    int     w;
    bit     busyOk;
    longint expRes;
    w = sml ? SML : BIG;
    expRes = (a * b) % n;
    @(negedge clk);
    if (sml) begin
      aSml = SML'(a); bSml = SML'(b); nSml = SML'(n); startSml = 1'b1;
    end else begin
      aBig = BIG'(a); bBig = BIG'(b); nBig = BIG'(n); startBig = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    startSml = 1'b0;
    startBig = 1'b0;
    check(selBusy(sml) == 1'b1, "R4", "busy after accept", longint'(selBusy(sml)), 1);
    lat = 0;
    busyOk = 1'b1;
    while (lat < 400) begin
      if (injectAt > 0 && lat == injectAt) begin
        if (sml) begin
          aSml = 1; bSml = 1; nSml = 3; startSml = 1'b1;
        end else begin
          aBig = 16'h0003; bBig = 16'h0005; nBig = 16'h0007; startBig = 1'b1;
        end
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
      startSml = 1'b0;
      startBig = 1'b0;
      if (selDone(sml)) break;
      if (!selBusy(sml)) busyOk = 1'b0;
    end
    check(lat == 3 * w + 1, "R4", "done latency", lat, 3 * w + 1);
    check(selRes(sml) == expRes, req, "residue", selRes(sml), expRes);
    if (injectAt > 0) begin
      check(busyOk, "R2", "busy held through ignored start", longint'(busyOk), 1);
      check(selBusy(sml) == 1'b0, "R2", "no queued operation", longint'(selBusy(sml)), 0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stimulus
    longint resHold;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values while rst is high
    check(busyBig == 0 && doneBig == 0, "R1", "big busy/done in reset", longint'({busyBig, doneBig}), 0);
    check(resBig == 0, "R1", "big result in reset", resBig, 0);
    check(busySml == 0 && doneSml == 0 && resSml == 0, "R1", "small outputs in reset",
          longint'({busySml, doneSml, resSml}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(busyBig == 0 && doneBig == 0 && resBig == 0, "R1", "big outputs after reset",
          longint'({busyBig, doneBig}), 0);

    // R3: exhaustive sweep on the 4-bit instance
    for (int n = 2; n < 16; n++)
      for (int a = 0; a < n; a++)
        for (int b = 0; b < n; b++)
          runOp(1'b1, a, b, n, "R3", 0);

    // R6: largest operands for every modulus length
    for (int k = 1; k < BIG; k++) begin
      longint nMax;
      nMax = (longint'(1) << (k + 1)) - 1;
      runOp(1'b0, nMax - 1, nMax - 1, nMax, "R6", 0);
    end

    // R7: aligned modulus at the window extremes
    runOp(1'b0, 16'h7FFF, 16'hFFFF - 1, 16'h8000 + 16'h7FFF, "R7", 0);
    runOp(1'b0, 32767, 32767, 32768, "R7", 0);
    runOp(1'b0, 12345, 32767, 32768, "R7", 0);
    runOp(1'b0, 32768, 32768, 32769, "R7", 0);
    runOp(1'b0, 65533, 65534, 65535, "R7", 0);
    runOp(1'b0, 1, 65534, 65535, "R7", 0);

    // R8: short moduli on the 16-bit instance
    runOp(1'b0, 1, 1, 2, "R8", 0);
    runOp(1'b0, 2, 2, 3, "R8", 0);
    runOp(1'b0, 4, 3, 5, "R8", 0);
    runOp(1'b0, 0, 6, 7, "R8", 0);
    for (int k = 1; k < BIG; k++) begin
      longint nLow;
      nLow = (longint'(1) << k) + 1;
      runOp(1'b0, nLow - 1, nLow / 2, nLow, "R8", 0);
    end

    // R3: random operands on the 16-bit instance
    for (int i = 0; i < 300; i++) begin
      longint n, a, b;
      n = longint'($urandom_range(65535, 2));
      a = longint'($urandom) % n;
      b = longint'($urandom) % n;
      runOp(1'b0, a, b, n, "R3", 0);
    end

    // R2: start pulsed mid-operation is ignored
    runOp(1'b0, 40000, 50001, 60013, "R2", 7);
    runOp(1'b1, 5, 6, 11, "R2", 4);

    // R5: result holds while inputs move and no start is given
    resHold = longint'(resBig);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      aBig = BIG'(i * 977);
      bBig = BIG'(i * 331);
      nBig = BIG'(i * 4099 + 3);
    end
    check(longint'(resBig) == resHold && doneBig == 0 && busyBig == 0, "R5",
          "result held while idle", resBig, resHold);
    resHold = longint'(resSml);
    repeat (5) @(negedge clk);
    check(longint'(resSml) == resHold && doneSml == 0, "R5", "small result held", resSml, resHold);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule